// File: doc/BRIEF.md
# Alternating Byte Bit-Population Counter

This block walks a byte-addressed memory region and keeps two running tallies. Bytes are taken two at a time. The first byte of each pair adds the number of its clear bits to one tally, and the second byte adds the number of its set bits to the other. A scan is launched by a start pulse that carries two longword addresses. The scan begins at the first address and reaches through the last byte of the final longword, which is the last longword address plus three.

Reads go out through a request channel with a valid/ready handshake. The data comes back on a response channel marked by a valid strobe. Only one read is outstanding at any time, so the memory can take any number of cycles to accept or to answer. Each byte is counted in one cycle by a combinational population count. When the final byte of the scan has been taken, the block pulses a done flag for one cycle. Both 16-bit counts then hold their values until the next scan is accepted.

Top module: `alt_byte_popcnt`

## Requirements
- R1: Out of reset, busy, done and both counts are 0. A start pulse seen while idle loads both addresses and clears both counts, and busy is 1 from the next cycle.
- R2: The first read request of a scan carries the first address. Each later request carries the previous request's address plus one. A new request is raised only after the response to the previous one has been taken.
- R3: A response taken at an even position in the scan (0, 2, 4, ... counted from the first byte) adds the number of 0 bits of the returned byte to the zero count.
- R4: A response taken at an odd position in the scan adds the number of 1 bits of the returned byte to the one count.
- R5: After each odd-position byte, the scan goes on if the next byte address is strictly below the last longword address plus 3, and ends otherwise. That limit is computed one bit wider than the address, so it does not wrap at the top of the address space.
- R6: When the first address is not below the last longword address plus 3, exactly one pair (two bytes) is still read and counted.
- R7: Each count is kept modulo 65536.
- R8: done is 1 for exactly one cycle: the cycle after the final response is taken. busy falls in that same cycle.
- R9: A start pulse while busy has no effect on the running scan, its addresses or its counts.
- R10: While idle and without a start, both counts keep their values.
- R11: A request stays raised with a stable address until ready is seen. Responses are taken only while waiting and only when valid, so any accept or return latency is tolerated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Scan launch pulse, taken only while idle |
| first_addr_i | input | AW | First longword address of the region |
| last_addr_i | input | AW | Last longword address of the region |
| req_valid_o | output | 1 | Read request raised |
| req_ready_i | input | 1 | Memory accepts the request this cycle |
| req_addr_o | output | AW | Byte address of the read |
| rsp_valid_i | input | 1 | Read data present |
| rsp_data_i | input | BW | Returned byte |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle pulse at scan end |
| zero_cnt_o | output | CW | Clear-bit tally of the first byte of each pair |
| one_cnt_o | output | CW | Set-bit tally of the second byte of each pair |

## Verification
busy and cleared counts appear one clock after the edge that takes the start pulse. Each count moves one clock after the edge that takes its response. done and the fall of busy come one clock after the edge that takes the final response. The reference model keeps "value due at the next sample" variables for each of these results. It compares them at every falling edge and only then advances them from the stimulus it drives at that same edge. The requests are checked in the cycle their handshake completes, against an address queue built when the start is accepted, and the memory holds back ready and the response by varying amounts so that the latency-tolerance paths are exercised.

// File: rtl/apc_pkg.sv
package apc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } apc_state_e;

  // number of set bits in a word of up to 64 bits
  function automatic int unsigned ones_of(input logic [63:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 64; i++) n += int'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/apc_popcnt.sv
module apc_popcnt #(
  parameter int BW = 8,
  localparam int IW = $clog2(BW + 1)
) (
  input  logic [BW-1:0] data_i,
  output logic [IW-1:0] ones_o,
  output logic [IW-1:0] zeros_o
);
  import apc_pkg::*;

  always_comb begin
    ones_o  = IW'(ones_of(64'(data_i)));
    zeros_o = IW'(BW) - ones_o;
  end

endmodule

// File: rtl/apc_tally.sv
module apc_tally #(
  parameter int CW = 16,
  parameter int IW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          add_i,
  input  logic [IW-1:0] inc_i,
  output logic [CW-1:0] count_o
);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     count_o <= '0;
    else if (clr_i)  count_o <= '0;
    else if (add_i)  count_o <= count_o + CW'(inc_i);
  end

  // R1
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> count_o == '0);

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !add_i) |=> $stable(count_o));

endmodule

// File: rtl/apc_seq.sv
module apc_seq #(
  parameter int AW = 16,
  localparam int PW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] first_addr_i,
  input  logic [AW-1:0] last_addr_i,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic [AW-1:0] req_addr_o,
  input  logic          rsp_valid_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          clr_o,
  output logic          take_even_o,
  output logic          take_odd_o
);
  import apc_pkg::*;

  apc_state_e    state_q;
  logic [PW-1:0] ptr_q;
  logic [PW-1:0] limit_q;
  logic          phase_q;
  logic          done_q;

  // named events
  logic          start_acc;
  logic          rsp_take;
  logic          scan_fin;
  logic [PW-1:0] ptr_nxt;

  assign start_acc = start_i && (state_q == ST_IDLE);
  assign rsp_take  = rsp_valid_i && (state_q == ST_WAIT);
  assign ptr_nxt   = ptr_q + PW'(1);
  assign scan_fin  = rsp_take && phase_q && !(ptr_nxt < limit_q);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      limit_q <= '0;
      phase_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= scan_fin;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          ptr_q   <= {1'b0, first_addr_i};
          limit_q <= {1'b0, last_addr_i} + PW'(3);
          phase_q <= 1'b0;
          state_q <= ST_REQ;
        end
        ST_REQ: if (req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid_i) begin
          ptr_q   <= ptr_nxt;
          phase_q <= ~phase_q;
          state_q <= scan_fin ? ST_IDLE : ST_REQ;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid_o = (state_q == ST_REQ);
  assign req_addr_o  = ptr_q[AW-1:0];
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign clr_o       = start_acc;
  assign take_even_o = rsp_take && !phase_q;
  assign take_odd_o  = rsp_take && phase_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)));

  // R9
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !scan_fin) |=> (busy_o && $stable(limit_q)));

  // R2
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_take && !scan_fin) |=> (req_valid_o && req_addr_o == AW'($past(req_addr_o) + AW'(1))));

endmodule

// File: rtl/alt_byte_popcnt.sv
module alt_byte_popcnt #(
  parameter int AW = 16,
  parameter int BW = 8,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] first_addr_i,
  input  logic [AW-1:0] last_addr_i,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic [AW-1:0] req_addr_o,
  input  logic          rsp_valid_i,
  input  logic [BW-1:0] rsp_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [CW-1:0] zero_cnt_o,
  output logic [CW-1:0] one_cnt_o
);
  localparam int IW = $clog2(BW + 1);
  localparam int NT = 2;

  logic          clr;
  logic          take_even;
  logic          take_odd;
  logic [IW-1:0] ones;
  logic [IW-1:0] zeros;
  logic [NT-1:0] add_sel;
  logic [IW-1:0] inc_sel [NT];
  logic [CW-1:0] cnt     [NT];

  apc_seq #(.AW(AW)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .first_addr_i (first_addr_i),
    .last_addr_i  (last_addr_i),
    .req_valid_o  (req_valid_o),
    .req_ready_i  (req_ready_i),
    .req_addr_o   (req_addr_o),
    .rsp_valid_i  (rsp_valid_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .clr_o        (clr),
    .take_even_o  (take_even),
    .take_odd_o   (take_odd)
  );

  apc_popcnt #(.BW(BW)) u_pop (
    .data_i  (rsp_data_i),
    .ones_o  (ones),
    .zeros_o (zeros)
  );

  // index 0: clear bits of even-position bytes, index 1: set bits of odd-position bytes
  assign add_sel    = {take_odd, take_even};
  assign inc_sel[0] = zeros;
  assign inc_sel[1] = ones;

  for (genvar gi = 0; gi < NT; gi++) begin : g_tally
    apc_tally #(.CW(CW), .IW(IW)) u_tally (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr),
      .add_i   (add_sel[gi]),
      .inc_i   (inc_sel[gi]),
      .count_o (cnt[gi])
    );
  end

  assign zero_cnt_o = cnt[0];
  assign one_cnt_o  = cnt[1];

endmodule

// File: tb/alt_byte_popcnt_tb.sv
module alt_byte_popcnt_tb;
  localparam int AW = 16;
  localparam int BW = 8;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] first_addr_i = '0;
  logic [AW-1:0] last_addr_i = '0;
  logic          req_valid_o;
  logic          req_ready_i = 1'b0;
  logic [AW-1:0] req_addr_o;
  logic          rsp_valid_i = 1'b0;
  logic [BW-1:0] rsp_data_i = '0;
  logic          busy_o;
  logic          done_o;
  logic [CW-1:0] zero_cnt_o;
  logic [CW-1:0] one_cnt_o;

  always #10 clk = ~clk;

  alt_byte_popcnt #(.AW(AW), .BW(BW), .CW(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i),
    .first_addr_i(first_addr_i), .last_addr_i(last_addr_i),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_addr_o(req_addr_o),
    .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i),
    .busy_o(busy_o), .done_o(done_o),
    .zero_cnt_o(zero_cnt_o), .one_cnt_o(one_cnt_o)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // memory contents: upper half holds 00/FF pairs, lower half a mixed pattern
  function automatic logic [7:0] mem_at(input int a);
    int m;
    m = a & 16'hFFFF;
    if ((m & 16'h8000) != 0) return ((m & 1) != 0) ? 8'hFF : 8'h00;
    return 8'(m * 29 + (m >> 8) * 7 + 91) ^ 8'(m >> 3);
  endfunction

  function automatic int bits_set(input logic [7:0] b);
    int n;
    n = 0;
    for (int k = 0; k < 8; k++) if (b[k]) n++;
    return n;
  endfunction

  // reference model state: values due at the next falling-edge sample
  bit          exp_busy = 0;
  bit          exp_done = 0;
  logic [15:0] mz = '0;
  logic [15:0] mo = '0;
  int          addr_q[$];
  int          total_bytes = 0;
  int          delivered = 0;
  int          issued = 0;
  bit          pend = 0;
  int          pend_addr = 0;
  int          lat = 0;
  int          cyc = 0;
  bit          slow = 0;
  int          scans_done = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      chk(busy_o === exp_busy, "R1 busy", busy_o, exp_busy);
      chk(done_o === exp_done, "R8 done", done_o, exp_done);
      chk(zero_cnt_o === mz, "R3 zero tally", zero_cnt_o, mz);
      chk(one_cnt_o === mo, "R4 one tally", one_cnt_o, mo);
      if (exp_done) begin
        chk(issued == total_bytes, "R5 reads per scan", issued, total_bytes);
        scans_done++;
      end
      exp_done = 0;
      rsp_valid_i = 1'b0;
      // start taken at the coming edge only if idle
      if (start_i && !exp_busy) begin
        int p, lim;
        p = int'(first_addr_i);
        lim = int'(last_addr_i) + 3;
        addr_q.delete();
        total_bytes = 0;
        issued = 0;
        delivered = 0;
        do begin
          addr_q.push_back(p & 16'hFFFF);
          addr_q.push_back((p + 1) & 16'hFFFF);
          total_bytes += 2;
          p += 2;
        end while (p < lim);
        exp_busy = 1;
        mz = '0;
        mo = '0;
      end else if (pend) begin
        if (lat == 0) begin
          logic [7:0] d;
          d = mem_at(pend_addr);
          rsp_valid_i = 1'b1;
          rsp_data_i = d;
          pend = 0;
          if ((delivered % 2) == 0) mz = mz + 16'(8 - bits_set(d));
          else                      mo = mo + 16'(bits_set(d));
          delivered++;
          if (delivered == total_bytes) begin
            exp_busy = 0;
            exp_done = 1;
          end
        end else begin
          lat--;
        end
      end
      req_ready_i = slow ? ((cyc % 3) != 1) : 1'b1;
      if (req_valid_o && req_ready_i) begin
        int e;
        e = (addr_q.size() > 0) ? addr_q.pop_front() : -1;
        chk(int'(req_addr_o) == e, "R2 request address", req_addr_o, e);
        chk(!pend, "R11 one outstanding", pend, 0);
        issued++;
        pend = 1;
        pend_addr = int'(req_addr_o);
        lat = slow ? (cyc % 3) : 0;
      end
    end
  end

  task automatic scan(input int f, input int l);
    int target;
    target = scans_done + 1;
    @(posedge clk); #1;
    first_addr_i = AW'(f);
    last_addr_i = AW'(l);
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    while (scans_done < target) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy_o && !done_o && zero_cnt_o == 0 && one_cnt_o == 0, "R1 reset state",
        {busy_o, done_o, zero_cnt_o, one_cnt_o}, 0);

    // R3 R4 basic region, fast memory
    scan(16'h0010, 16'h0018);
    chk(issued == 12, "R5 twelve bytes", issued, 12);

    // R11 slow accept and slow return
    slow = 1;
    scan(16'h0100, 16'h0140);
    chk(issued == 68, "R11 slow scan length", issued, 68);

    // R6 first above the limit: one pair
    scan(16'h0200, 16'h0100);
    chk(issued == 2, "R6 single pair", issued, 2);

    // R5 equal addresses cover one longword
    slow = 0;
    scan(16'h0300, 16'h0300);
    chk(issued == 4, "R5 one longword", issued, 4);

    // R9 start while busy is ignored
    slow = 1;
    fork
      scan(16'h0040, 16'h0060);
      begin
        repeat (10) @(posedge clk); #1;
        first_addr_i = 16'h7000;
        last_addr_i = 16'h7100;
        start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
      end
    join
    chk(issued == 36, "R9 original scan kept", issued, 36);

    // R10 idle hold
    begin
      logic [15:0] hz, ho;
      hz = zero_cnt_o;
      ho = one_cnt_o;
      repeat (20) @(negedge clk);
      chk(zero_cnt_o == hz && one_cnt_o == ho, "R10 idle hold",
          {zero_cnt_o, one_cnt_o}, {hz, ho});
    end

    // R5 limit near top of address space must not wrap
    slow = 0;
    scan(16'hFFF8, 16'hFFFC);
    chk(issued == 8, "R5 top of space", issued, 8);

    // R7 tallies wrap modulo 65536 (8192 pairs of 00/FF)
    scan(16'h8000, 16'hBFFC);
    chk(zero_cnt_o == 0 && one_cnt_o == 0, "R7 wrap", {zero_cnt_o, one_cnt_o}, 0);

    repeat (3) @(negedge clk);
    summary();
  end

endmodule